// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Legacy Line Router

This block gathers level-sensitive interrupt requests from PCI devices and presents them as sixteen legacy interrupt-controller input levels. Each request names a device/function number, one of the four device interrupt pins (INTA to INTD, coded 0 to 3) and a level. The block keeps the level of every pin of every device/function separately. Each pin is rotated by its slot number onto one of four shared interrupt links. The rotation spreads the pins of devices in neighbouring slots across the links.

Each link has a programmable steering byte. The byte selects which legacy line the link drives, or turns the route off. Several links may target the same legacy line. That line is then the OR of their levels. The steering bytes are written and read through a byte-wide configuration port. Every other configuration offset belongs to other logic and is ignored here.

A parameter picks one of two reset profiles. In the first, every route is off. In the second, links 0 and 1 go to line 10 and links 2 and 3 go to line 11.

Top module: `pci_irq_router`

## Requirements
- R1: With the default profile, synchronous reset leaves all four steering bytes at 0x80 (route off) and all sixteen legacy lines low.
- R2: With the split profile, reset leaves the steering bytes of links 0 to 3 at 0x0A, 0x0A, 0x0B and 0x0B.
- R3: A request from device/function byte F on pin P (0 = INTA to 3 = INTD) feeds link (P + (F >> 3) - 1) mod 4.
- R4: A link whose steering byte holds a value V below 16 drives legacy line V. A request or configuration write sampled on a clock edge shows on the lines just after that edge.
- R5: A steering byte of 16 or more drives no line. This includes any value with bit 7 set.
- R6: A legacy line is the OR of the levels of every link whose steering byte selects it.
- R7: Levels are held per device/function and per pin. A link stays high while any request that rotates onto it is high, and falls only when all of them have been released.
- R8: Rewriting a steering byte while its link is high moves the level to the new line after the write edge and leaves the old line low, unless another link still drives it.
- R9: The link 0 to 3 steering bytes sit at configuration offsets 0x60 to 0x63, in that order. Reading one of those offsets returns the stored byte unchanged, and reading any other offset returns 0.
- R10: A write to any configuration offset outside 0x60 to 0x63 changes no steering byte and no legacy line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A pin level update is presented this cycle |
| req_devfn | input | 8 | Device/function byte of the requester |
| req_pin | input | 2 | Interrupt pin, 0 = INTA to 3 = INTD |
| req_level | input | 1 | New level of that pin |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration offset for reads and writes |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for cfg_addr |
| irq_lines | output | 16 | Legacy interrupt line levels |

## Verification
The hardest situation to reach from the ports is a legacy line that two separate mechanisms keep high at the same time. It can be held by two links that share a target, or by two devices that rotate onto one link, while one source at a time is removed or re-steered. The stimulus first programs distinct targets and walks every slot and pin pair through the rotation. It then points two links at one line and raises a pin on each. It also raises pins from two different slots that land on the same link. Sources are released one by one, and a steering byte is rewritten while its link is held high. A behavioural model of per-pin levels and steering bytes is compared with the outputs on every clock throughout.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int PIN_COUNT   = 4;
    localparam int LINK_COUNT  = 4;
    localparam int LINK_W      = $clog2(LINK_COUNT);
    localparam int CFG_W       = 8;
    localparam logic [CFG_W-1:0] STEER_BASE = 8'h60;
    localparam logic [CFG_W-1:0] STEER_OFF  = 8'h80;

    typedef logic [CFG_W-1:0] steer_t;

    typedef enum logic [0:0] {
        PROFILE_ALL_OFF = 1'b0,
        PROFILE_SPLIT   = 1'b1
    } reset_profile_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] devfn;
        logic [1:0] pin;
        logic       level;
    } pin_req_t;

    // Rotation of a device pin onto a shared link by slot number.
    function automatic logic [LINK_W-1:0] rotate_pin(input logic [7:0] devfn,
                                                     input logic [1:0] pin);
        logic [LINK_W-1:0] slot_lo;
        slot_lo = devfn[3 +: LINK_W];
        return LINK_W'(pin) + slot_lo - LINK_W'(1);
    endfunction

    function automatic steer_t steer_reset(input reset_profile_e profile,
                                           input int idx);
        if (profile == PROFILE_SPLIT)
            return (idx < 2) ? 8'h0A : 8'h0B;
        return STEER_OFF;
    endfunction

endpackage

// File: rtl/irq_pin_store.sv
module irq_pin_store
    import irq_router_pkg::*;
#(
    parameter int DEV_COUNT = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pin_req_t              req,
    output logic [LINK_COUNT-1:0] link_lvl
);
    logic [DEV_COUNT-1:0][PIN_COUNT-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= '0;
        else if (req.valid && (int'(req.devfn) < DEV_COUNT))
            lvl_q[req.devfn][req.pin] <= req.level;
    end

    always_comb begin
        link_lvl = '0;
        for (int d = 0; d < DEV_COUNT; d++) begin
            for (int p = 0; p < PIN_COUNT; p++) begin
                if (lvl_q[d][p])
                    link_lvl[rotate_pin(8'(d), 2'(p))] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
    import irq_router_pkg::*;
#(
    parameter reset_profile_e PROFILE = PROFILE_ALL_OFF
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_wr,
    input  logic [CFG_W-1:0]                 cfg_addr,
    input  logic [CFG_W-1:0]                 cfg_wdata,
    output logic [CFG_W-1:0]                 cfg_rdata,
    output logic [LINK_COUNT-1:0][CFG_W-1:0] steer_q
);
    for (genvar i = 0; i < LINK_COUNT; i++) begin : g_steer
        localparam logic [CFG_W-1:0] OFFS = STEER_BASE + CFG_W'(i);
        always_ff @(posedge clk) begin
            if (rst)
                steer_q[i] <= steer_reset(PROFILE, i);
            else if (cfg_wr && (cfg_addr == OFFS))
                steer_q[i] <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < LINK_COUNT; i++) begin
            if (cfg_addr == STEER_BASE + CFG_W'(i))
                cfg_rdata = steer_q[i];
        end
    end
endmodule

// File: rtl/irq_line_steer.sv
module irq_line_steer
    import irq_router_pkg::*;
#(
    parameter int LINE_COUNT = 16
) (
    input  logic [LINK_COUNT-1:0]            link_lvl,
    input  logic [LINK_COUNT-1:0][CFG_W-1:0] steer_q,
    output logic [LINE_COUNT-1:0]            lines
);
    for (genvar l = 0; l < LINE_COUNT; l++) begin : g_line
        always_comb begin
            lines[l] = 1'b0;
            for (int k = 0; k < LINK_COUNT; k++) begin
                if (link_lvl[k] && (int'(steer_q[k]) == l))
                    lines[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import irq_router_pkg::*;
#(
    parameter int             DEV_COUNT  = 256,
    parameter int             LINE_COUNT = 16,
    parameter reset_profile_e PROFILE    = PROFILE_ALL_OFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [7:0]            req_devfn,
    input  logic [1:0]            req_pin,
    input  logic                  req_level,
    input  logic                  cfg_wr,
    input  logic [CFG_W-1:0]      cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output logic [CFG_W-1:0]      cfg_rdata,
    output logic [LINE_COUNT-1:0] irq_lines
);
    pin_req_t                         req;
    logic [LINK_COUNT-1:0]            link_lvl;
    logic [LINK_COUNT-1:0][CFG_W-1:0] steer_q;

    assign req = '{valid: req_valid, devfn: req_devfn, pin: req_pin, level: req_level};

    irq_pin_store #(.DEV_COUNT(DEV_COUNT)) u_store (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .link_lvl (link_lvl)
    );

    irq_steer_regs #(.PROFILE(PROFILE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .steer_q   (steer_q)
    );

    irq_line_steer #(.LINE_COUNT(LINE_COUNT)) u_steer (
        .link_lvl (link_lvl),
        .steer_q  (steer_q),
        .lines    (irq_lines)
    );
endmodule

// File: rtl/pci_irq_router_chk.sv
module pci_irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int             LINE_COUNT = 16,
    parameter reset_profile_e PROFILE    = PROFILE_ALL_OFF
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             cfg_wr,
    input logic [CFG_W-1:0]                 cfg_addr,
    input logic [CFG_W-1:0]                 cfg_wdata,
    input logic [CFG_W-1:0]                 cfg_rdata,
    input logic [LINK_COUNT-1:0]            link_lvl,
    input logic [LINK_COUNT-1:0][CFG_W-1:0] steer_q,
    input logic [LINE_COUNT-1:0]            irq_lines
);
    logic addr_in_map;
    logic all_off;

    assign addr_in_map = (cfg_addr >= STEER_BASE) &&
                         (cfg_addr < STEER_BASE + CFG_W'(LINK_COUNT));

    always_comb begin
        all_off = 1'b1;
        for (int k = 0; k < LINK_COUNT; k++)
            if (int'(steer_q[k]) < LINE_COUNT) all_off = 1'b0;
    end

    // R1 / R2: reset profile lands in the steering bytes
    a_r1_reset_steer: assert property (@(posedge clk)
        rst |=> (steer_q[0] == steer_reset(PROFILE, 0)) &&
                (steer_q[3] == steer_reset(PROFILE, 3)));

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (link_lvl == '0));

    // R4: a high link with an in-range steering byte drives its line
    for (genvar k = 0; k < LINK_COUNT; k++) begin : g_link
        a_r4_link_drives: assert property (@(posedge clk) disable iff (rst)
            (link_lvl[k] && (int'(steer_q[k]) < LINE_COUNT))
                |-> irq_lines[steer_q[k][$clog2(LINE_COUNT)-1:0]]);
    end

    // R5: with every route off, nothing is driven
    a_r5_all_off_quiet: assert property (@(posedge clk) disable iff (rst)
        all_off |-> (irq_lines == '0));

    // R6: OR-sharing can never produce more lines than high links
    a_r6_lines_bounded: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_lines) <= $countones(link_lvl));

    // R9: a written steering byte reads back unchanged
    a_r9_readback: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && addr_in_map) |=>
            ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata))));

    // R10: out-of-map writes leave the steering bytes alone
    a_r10_foreign_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !addr_in_map) |=> $stable(steer_q));
endmodule

bind pci_irq_router pci_irq_router_chk #(
    .LINE_COUNT (LINE_COUNT),
    .PROFILE    (PROFILE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .link_lvl  (link_lvl),
    .steer_q   (steer_q),
    .irq_lines (irq_lines)
);

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;
    import irq_router_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_devfn = '0;
    logic [1:0]  req_pin = '0;
    logic        req_level = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] irq_lines;
    logic [7:0]  alt_addr = 8'h60;
    logic [7:0]  alt_rdata;
    logic [15:0] alt_lines;

    int checks = 0;
    int fails  = 0;

    bit m_lvl [256][4];
    int m_steer [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_irq_router uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_devfn(req_devfn),
        .req_pin(req_pin), .req_level(req_level), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_lines(irq_lines)
    );

    pci_irq_router #(.PROFILE(PROFILE_SPLIT)) uut_alt (
        .clk(clk), .rst(rst), .req_valid(1'b0), .req_devfn(8'h00),
        .req_pin(2'b00), .req_level(1'b0), .cfg_wr(1'b0),
        .cfg_addr(alt_addr), .cfg_wdata(8'h00), .cfg_rdata(alt_rdata),
        .irq_lines(alt_lines)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int link_of(input int devfn, input int pin);
        return (((pin + (devfn / 8) - 1) % 4) + 4) % 4;
    endfunction

    function automatic logic [15:0] model_lines();
        bit lk [4];
        logic [15:0] r;
        for (int k = 0; k < 4; k++) lk[k] = 0;
        for (int d = 0; d < 256; d++)
            for (int p = 0; p < 4; p++)
                if (m_lvl[d][p]) lk[link_of(d, p)] = 1;
        r = '0;
        for (int k = 0; k < 4; k++)
            if (lk[k] && m_steer[k] >= 0 && m_steer[k] < 16) r[m_steer[k]] = 1'b1;
        return r;
    endfunction

    function automatic int model_read(input int addr);
        if (addr >= 'h60 && addr <= 'h63) return m_steer[addr - 'h60];
        return 0;
    endfunction

    task automatic model_edge();
        if (rst) begin
            for (int d = 0; d < 256; d++)
                for (int p = 0; p < 4; p++) m_lvl[d][p] = 0;
            for (int k = 0; k < 4; k++) m_steer[k] = 'h80;
        end else begin
            if (req_valid) m_lvl[req_devfn][req_pin] = req_level;
            if (cfg_wr && cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
                m_steer[cfg_addr - 8'h60] = cfg_wdata;
        end
    endtask

    task automatic tick(input string tag);
        logic [15:0] el;
        int er;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        el = model_lines();
        er = model_read(cfg_addr);
        chk(irq_lines == el, {tag, " lines vs model"}, irq_lines, el);
        chk(cfg_rdata == er[7:0], {tag, " rdata vs model"}, cfg_rdata, er);
    endtask

    task automatic do_req(input int devfn, input int pin, input bit lvl, input string tag);
        req_valid = 1'b1; req_devfn = 8'(devfn); req_pin = 2'(pin); req_level = lvl;
        tick(tag);
        req_valid = 1'b0;
    endtask

    task automatic do_wr(input int addr, input int data, input string tag);
        cfg_wr = 1'b1; cfg_addr = 8'(addr); cfg_wdata = 8'(data);
        tick(tag);
        cfg_wr = 1'b0;
    endtask

    task automatic do_rd(input int addr, input int exp, input string tag);
        cfg_addr = 8'(addr);
        tick(tag);
        chk(cfg_rdata == 8'(exp), tag, cfg_rdata, exp);
    endtask

    initial begin
        int tgt [4];
        int ln;
        tgt[0] = 3; tgt[1] = 5; tgt[2] = 7; tgt[3] = 9;

        @(negedge clk);
        rst = 1'b1;
        tick("R1 reset");
        tick("R1 reset");
        rst = 1'b0;
        tick("R1 idle");
        chk(irq_lines == 16'h0, "R1 lines quiet", irq_lines, 0);
        for (int k = 0; k < 4; k++) begin
            do_rd('h60 + k, 'h80, "R1 steer off after reset");
            alt_addr = 8'(8'h60 + k);
            #1;
            chk(alt_rdata == ((k < 2) ? 8'h0A : 8'h0B), "R2 split profile reset",
                alt_rdata, (k < 2) ? 'h0A : 'h0B);
        end

        // Program distinct targets and read them back
        for (int k = 0; k < 4; k++) do_wr('h60 + k, tgt[k], "R4 program");
        for (int k = 0; k < 4; k++) do_rd('h60 + k, tgt[k], "R9 readback");

        // Rotation over every slot and pin
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                do_req(s * 8 + (s % 8), p, 1'b1, "R3 rotate raise");
                ln = tgt[(p + s + 3) % 4];
                chk(irq_lines == 16'(1 << ln), "R3 rotation target", irq_lines, 1 << ln);
                do_req(s * 8 + (s % 8), p, 1'b0, "R3 rotate drop");
                chk(irq_lines == 16'h0, "R3 released", irq_lines, 0);
            end
        end

        // Two links sharing one line: slot 1 pin 0 -> link 0, slot 1 pin 1 -> link 1
        do_wr('h60, 4, "R6 share");
        do_wr('h61, 4, "R6 share");
        do_req('h08, 0, 1'b1, "R6 first");
        do_req('h08, 1, 1'b1, "R6 second");
        chk(irq_lines == 16'h0010, "R6 shared high", irq_lines, 'h10);
        do_req('h08, 0, 1'b0, "R6 drop first");
        chk(irq_lines == 16'h0010, "R6 held by other link", irq_lines, 'h10);
        do_req('h08, 1, 1'b0, "R6 drop second");
        chk(irq_lines == 16'h0000, "R6 both dropped", irq_lines, 0);

        // Two devices on one link: slot 1 pin 0 and slot 2 pin 3 both feed link 0
        do_req('h08, 0, 1'b1, "R7 dev a");
        do_req('h10, 3, 1'b1, "R7 dev b");
        do_req('h08, 0, 1'b0, "R7 drop a");
        chk(irq_lines == 16'h0010, "R7 link held by second device", irq_lines, 'h10);
        do_req('h10, 3, 1'b0, "R7 drop b");
        chk(irq_lines == 16'h0000, "R7 link released", irq_lines, 0);

        // Disabled routes on link 2 (slot 1 pin 2)
        do_wr('h62, 'h80, "R5 off");
        do_req('h08, 2, 1'b1, "R5 raise");
        chk(irq_lines == 16'h0, "R5 bit7 drives nothing", irq_lines, 0);
        do_wr('h62, 'h20, "R5 out of range");
        chk(irq_lines == 16'h0, "R5 value 32 drives nothing", irq_lines, 0);
        do_wr('h62, 'h10, "R5 value 16");
        chk(irq_lines == 16'h0, "R5 value 16 drives nothing", irq_lines, 0);
        do_wr('h62, 'h0F, "R5 top line");
        chk(irq_lines == 16'h8000, "R5 value 15 drives line 15", irq_lines, 'h8000);

        // Re-route while held
        do_wr('h62, 12, "R8 reroute");
        chk(irq_lines == 16'h1000, "R8 moved to line 12", irq_lines, 'h1000);
        do_wr('h62, 4, "R8 onto shared target");
        do_req('h08, 0, 1'b1, "R8 raise link 0");
        do_wr('h62, 6, "R8 leave shared");
        chk(irq_lines == 16'h0050, "R8 old line kept by link 0", irq_lines, 'h50);
        do_req('h08, 0, 1'b0, "R8 drop link 0");

        // Foreign offsets
        do_wr('h64, 1, "R10 foreign");
        do_wr('h5F, 1, "R10 foreign");
        do_wr('hE2, 1, "R10 foreign");
        chk(irq_lines == 16'h0040, "R10 lines unchanged", irq_lines, 'h40);
        do_rd('h62, 6, "R10 steer unchanged");
        do_rd('h64, 0, "R9 foreign offset reads zero");
        do_rd('h00, 0, "R9 offset 0 reads zero");

        // Reset again with a level held
        rst = 1'b1;
        tick("R1 second reset");
        rst = 1'b0;
        chk(irq_lines == 16'h0, "R1 lines cleared", irq_lines, 0);
        do_rd('h62, 'h80, "R1 steer restored");

        finish_run();
    end
endmodule